// File: doc/BRIEF.md
# Coherent Cache Line Controller

This block is the cache controller for one processor in a multiprocessor system. It keeps a small array of cachelines, and each line carries a MESI state. Two engines run at the same time and share the line array. The processor engine serves blocking loads and stores. When a line is Invalid, or when a store lacks ownership, it sends a request to a central coherence controller. The snoop engine answers share and invalidate commands from that controller.

Each line has its own test-and-set lock. An engine must hold the lock of a line before it reads or writes that line's state or data. So neither engine can change a line while the other is in the middle of working on it. The processor engine lets go of the lock while it waits for the controller. This keeps the snoop engine free to serve other traffic during that wait. When both engines ask for a free lock in the same cycle, the snoop engine gets it.

Every channel holds at most one message. A request is taken only while the matching ready output is high. Responses are one-cycle valid pulses.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` and `snp_req_ready` are high, and `cpu_rsp_valid`, `mem_req_valid` and `snp_rsp_valid` are low.
- R2: A load to an Invalid line never returns data until the line has been filled. The load issues one request with `mem_req_own`=0 and returns the data from the controller's reply. A load to a line in any other state returns the stored data without issuing a request.
- R3: A store to a line in Exclusive or Modified writes its data locally and issues no request. The line ends in Modified, and the store's response echoes the written data.
- R4: A store to a Shared or Invalid line issues a request with `mem_req_own`=1. The line becomes Modified only after a reply with `mem_rsp_excl`=1.
- R5: A reply to a load with `mem_rsp_excl`=1 leaves the line Exclusive. A reply with `mem_rsp_excl`=0 leaves it Shared. A later store then tells the two states apart by whether it issues a request.
- R6: A share snoop (`snp_req_kind`=0) reports `snp_rsp_hit`=1 unless the line is Invalid. A Modified line reports `snp_rsp_dirty`=1 with its data. Modified and Exclusive lines become Shared, and other lines keep their state.
- R7: An invalidate snoop (`snp_req_kind`=1) reports hit and dirty from the line's prior state, with the data when the line was Modified. It leaves the line Invalid. `snp_rsp_data` is 0 whenever `snp_rsp_dirty`=0.
- R8: While the processor engine waits for the controller's reply, the snoop engine still accepts and answers snoops.
- R9: Only one engine at a time holds a line's lock, and the two engines never write the same line in the same cycle. On a same-cycle request for a free lock, the snoop engine wins.
- R10: A `mem_rsp_valid` pulse that arrives while no request is outstanding is ignored.
- R11: `cpu_req_ready` stays low from the accepted processor request until its response.
- R12: If an ownership request gets a reply with `mem_rsp_excl`=0, the line takes the reply data as Shared. The engine then issues the ownership request again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_line | input | IDX_W | Line index |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Processor engine idle, request accepted |
| cpu_rsp_valid | output | 1 | Response pulse |
| cpu_rsp_rdata | output | DATA_W | Load data, or store data echoed |
| mem_req_valid | output | 1 | Request pulse to the coherence controller |
| mem_req_own | output | 1 | 1 = ownership (permission to store), 0 = read |
| mem_req_line | output | IDX_W | Requested line |
| mem_rsp_valid | input | 1 | Controller reply pulse |
| mem_rsp_excl | input | 1 | Reply grants exclusive ownership |
| mem_rsp_data | input | DATA_W | Line data from the controller |
| snp_req_valid | input | 1 | Snoop command present |
| snp_req_kind | input | 1 | 0 = share, 1 = invalidate |
| snp_req_line | input | IDX_W | Snooped line |
| snp_req_ready | output | 1 | Snoop engine idle |
| snp_rsp_valid | output | 1 | Snoop answer pulse |
| snp_rsp_hit | output | 1 | Line was not Invalid |
| snp_rsp_dirty | output | 1 | Line was Modified and its data is returned |
| snp_rsp_data | output | DATA_W | Written-back data |

## Verification
The main function is tried with three kinds of stimulus.

- **Directed state walk.** One line goes through Exclusive, Modified, Shared and Invalid in turn. This separates silent local writes from writes that need a request.
- **Denial and stray replies.** An ownership request is first answered without the grant. This separates the retry path from a wrongful early entry into Modified. A stray reply while idle shows whether the fill path ignores it.
- **Two-engine timing.** Snoops are sent while a load is still waiting on the controller, and a store and an invalidate hit the same Exclusive line in the same cycle. These separate engines that really run in parallel from ones that serialize, and show which engine wins a tie: only a snoop-first order yields a clean hit followed by an ownership request.

Finally, a long seeded random mix of loads, stores and snoops over all lines checks each answer against a bench model of the MESI state.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } mesi_t;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_MAIN  = 2'd1,
      OWN_SNOOP = 2'd2
   } lock_own_t;

   typedef enum logic [1:0] {
      M_IDLE = 2'd0,
      M_LOCK = 2'd1,
      M_WAIT = 2'd2,
      M_FILL = 2'd3
   } main_st_t;
endpackage

// File: rtl/ccl_line_lock.sv
module ccl_line_lock
   import ccl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic main_req,
   input  logic snp_req,
   input  logic main_rel,
   input  logic snp_rel,
   output logic main_held,
   output logic snp_held
);
   lock_own_t owner;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner <= OWN_NONE;
      end else begin
         case (owner)
            OWN_MAIN:  if (main_rel) owner <= OWN_NONE;
            OWN_SNOOP: if (snp_rel)  owner <= OWN_NONE;
            default: begin
               // test-and-set: a free lock goes to one taker, snoop first
               if (snp_req)       owner <= OWN_SNOOP;
               else if (main_req) owner <= OWN_MAIN;
            end
         endcase
      end
   end

   assign main_held = (owner == OWN_MAIN);
   assign snp_held  = (owner == OWN_SNOOP);
endmodule

// File: rtl/ccl_line_store.sv
module ccl_line_store
   import ccl_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              main_we,
   input  logic [IDX_W-1:0]                  main_line,
   input  mesi_t                             main_st,
   input  logic [DATA_W-1:0]                 main_data,
   input  logic                              snp_we,
   input  logic [IDX_W-1:0]                  snp_line,
   input  mesi_t                             snp_st,
   output logic [NUM_LINES-1:0][1:0]         st_flat,
   output logic [NUM_LINES-1:0][DATA_W-1:0]  data_flat
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_flat[i]   <= ST_I;
            data_flat[i] <= '0;
         end else if (main_we && main_line == IDX_W'(i)) begin
            st_flat[i]   <= main_st;
            data_flat[i] <= main_data;
         end else if (snp_we && snp_line == IDX_W'(i)) begin
            st_flat[i]   <= snp_st;
         end
      end
   end
endmodule

// File: rtl/ccl_main_eng.sv
module ccl_main_eng
   import ccl_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [IDX_W-1:0]  cpu_req_line,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_req_ready,
   output logic              cpu_rsp_valid,
   output logic [DATA_W-1:0] cpu_rsp_rdata,
   output logic              mem_req_valid,
   output logic              mem_req_own,
   output logic [IDX_W-1:0]  mem_req_line,
   input  logic              mem_rsp_valid,
   input  logic              mem_rsp_excl,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              lock_req,
   input  logic              lock_held,
   output logic              lock_rel,
   output logic [IDX_W-1:0]  cur_line,
   input  mesi_t             line_st,
   input  logic [DATA_W-1:0] line_data,
   output logic              we,
   output mesi_t             wr_st,
   output logic [DATA_W-1:0] wr_data
);
   main_st_t          state;
   logic              q_write;
   logic              q_excl;
   logic [IDX_W-1:0]  q_line;
   logic [DATA_W-1:0] q_wdata;
   logic [DATA_W-1:0] q_fdata;
   logic              hit;

   assign hit = q_write ? (line_st == ST_E || line_st == ST_M) : (line_st != ST_I);

   always_comb begin
      lock_req = (state == M_LOCK) || (state == M_FILL);
      lock_rel = lock_req && lock_held;
      we       = 1'b0;
      wr_st    = ST_I;
      wr_data  = q_wdata;
      if (state == M_LOCK && lock_held && q_write && hit) begin
         we    = 1'b1;
         wr_st = ST_M;
      end else if (state == M_FILL && lock_held) begin
         we = 1'b1;
         if (!q_write) begin
            wr_st   = q_excl ? ST_E : ST_S;
            wr_data = q_fdata;
         end else if (q_excl) begin
            wr_st = ST_M;
         end else begin
            wr_st   = ST_S;
            wr_data = q_fdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= M_IDLE;
         q_write       <= 1'b0;
         q_excl        <= 1'b0;
         q_line        <= '0;
         q_wdata       <= '0;
         q_fdata       <= '0;
         cpu_rsp_valid <= 1'b0;
         cpu_rsp_rdata <= '0;
         mem_req_valid <= 1'b0;
         mem_req_own   <= 1'b0;
      end else begin
         cpu_rsp_valid <= 1'b0;
         mem_req_valid <= 1'b0;
         case (state)
            M_IDLE: if (cpu_req_valid) begin
               q_write <= cpu_req_write;
               q_line  <= cpu_req_line;
               q_wdata <= cpu_req_wdata;
               state   <= M_LOCK;
            end
            M_LOCK: if (lock_held) begin
               if (hit) begin
                  cpu_rsp_valid <= 1'b1;
                  cpu_rsp_rdata <= q_write ? q_wdata : line_data;
                  state         <= M_IDLE;
               end else begin
                  mem_req_valid <= 1'b1;
                  mem_req_own   <= q_write;
                  state         <= M_WAIT;
               end
            end
            M_WAIT: if (mem_rsp_valid) begin
               q_fdata <= mem_rsp_data;
               q_excl  <= mem_rsp_excl;
               state   <= M_FILL;
            end
            default: if (lock_held) begin
               if (q_write && !q_excl) begin
                  state <= M_LOCK;
               end else begin
                  cpu_rsp_valid <= 1'b1;
                  cpu_rsp_rdata <= q_write ? q_wdata : q_fdata;
                  state         <= M_IDLE;
               end
            end
         endcase
      end
   end

   assign cpu_req_ready = (state == M_IDLE);
   assign mem_req_line  = q_line;
   assign cur_line      = q_line;
endmodule

// File: rtl/ccl_snoop_eng.sv
module ccl_snoop_eng
   import ccl_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_req_valid,
   input  logic              snp_req_kind,
   input  logic [IDX_W-1:0]  snp_req_line,
   output logic              snp_req_ready,
   output logic              snp_rsp_valid,
   output logic              snp_rsp_hit,
   output logic              snp_rsp_dirty,
   output logic [DATA_W-1:0] snp_rsp_data,
   output logic              lock_req,
   input  logic              lock_held,
   output logic              lock_rel,
   output logic [IDX_W-1:0]  cur_line,
   input  mesi_t             line_st,
   input  logic [DATA_W-1:0] line_data,
   output logic              we,
   output mesi_t             wr_st
);
   logic             busy;
   logic             q_inval;
   logic [IDX_W-1:0] q_line;

   always_comb begin
      lock_req = busy;
      lock_rel = busy && lock_held;
      we       = lock_rel;
      if (q_inval)
         wr_st = ST_I;
      else if (line_st == ST_M || line_st == ST_E)
         wr_st = ST_S;
      else
         wr_st = line_st;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy          <= 1'b0;
         q_inval       <= 1'b0;
         q_line        <= '0;
         snp_rsp_valid <= 1'b0;
         snp_rsp_hit   <= 1'b0;
         snp_rsp_dirty <= 1'b0;
         snp_rsp_data  <= '0;
      end else begin
         snp_rsp_valid <= 1'b0;
         if (!busy) begin
            if (snp_req_valid) begin
               busy    <= 1'b1;
               q_inval <= snp_req_kind;
               q_line  <= snp_req_line;
            end
         end else if (lock_held) begin
            busy          <= 1'b0;
            snp_rsp_valid <= 1'b1;
            snp_rsp_hit   <= (line_st != ST_I);
            snp_rsp_dirty <= (line_st == ST_M);
            snp_rsp_data  <= (line_st == ST_M) ? line_data : '0;
         end
      end
   end

   assign snp_req_ready = !busy;
   assign cur_line      = q_line;
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
   import ccl_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [IDX_W-1:0]  cpu_req_line,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_req_ready,
   output logic              cpu_rsp_valid,
   output logic [DATA_W-1:0] cpu_rsp_rdata,
   output logic              mem_req_valid,
   output logic              mem_req_own,
   output logic [IDX_W-1:0]  mem_req_line,
   input  logic              mem_rsp_valid,
   input  logic              mem_rsp_excl,
   input  logic [DATA_W-1:0] mem_rsp_data,
   input  logic              snp_req_valid,
   input  logic              snp_req_kind,
   input  logic [IDX_W-1:0]  snp_req_line,
   output logic              snp_req_ready,
   output logic              snp_rsp_valid,
   output logic              snp_rsp_hit,
   output logic              snp_rsp_dirty,
   output logic [DATA_W-1:0] snp_rsp_data
);
   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [NUM_LINES-1:0][1:0]        st_flat;
   logic [NUM_LINES-1:0][DATA_W-1:0] data_flat;
   logic [NUM_LINES-1:0]             m_lreq_v, s_lreq_v, m_held_v, s_held_v;

   logic              m_lreq, m_held, m_rel, m_we;
   logic [IDX_W-1:0]  m_line;
   mesi_t             m_wr_st;
   logic [DATA_W-1:0] m_wr_data;
   logic              s_lreq, s_held, s_rel, s_we;
   logic [IDX_W-1:0]  s_line;
   mesi_t             s_wr_st;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_lock
      assign m_lreq_v[i] = m_lreq && m_line == IDX_W'(i);
      assign s_lreq_v[i] = s_lreq && s_line == IDX_W'(i);
      ccl_line_lock u_lock (
         .clk       (clk),
         .rst_n     (rst_n),
         .main_req  (m_lreq_v[i]),
         .snp_req   (s_lreq_v[i]),
         .main_rel  (m_rel && m_line == IDX_W'(i)),
         .snp_rel   (s_rel && s_line == IDX_W'(i)),
         .main_held (m_held_v[i]),
         .snp_held  (s_held_v[i])
      );
   end

   assign m_held = m_held_v[m_line];
   assign s_held = s_held_v[s_line];

   ccl_line_store #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .main_we   (m_we),
      .main_line (m_line),
      .main_st   (m_wr_st),
      .main_data (m_wr_data),
      .snp_we    (s_we),
      .snp_line  (s_line),
      .snp_st    (s_wr_st),
      .st_flat   (st_flat),
      .data_flat (data_flat)
   );

   ccl_main_eng #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_main (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req_valid (cpu_req_valid),
      .cpu_req_write (cpu_req_write),
      .cpu_req_line  (cpu_req_line),
      .cpu_req_wdata (cpu_req_wdata),
      .cpu_req_ready (cpu_req_ready),
      .cpu_rsp_valid (cpu_rsp_valid),
      .cpu_rsp_rdata (cpu_rsp_rdata),
      .mem_req_valid (mem_req_valid),
      .mem_req_own   (mem_req_own),
      .mem_req_line  (mem_req_line),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_excl  (mem_rsp_excl),
      .mem_rsp_data  (mem_rsp_data),
      .lock_req      (m_lreq),
      .lock_held     (m_held),
      .lock_rel      (m_rel),
      .cur_line      (m_line),
      .line_st       (mesi_t'(st_flat[m_line])),
      .line_data     (data_flat[m_line]),
      .we            (m_we),
      .wr_st         (m_wr_st),
      .wr_data       (m_wr_data)
   );

   ccl_snoop_eng #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
      .clk           (clk),
      .rst_n         (rst_n),
      .snp_req_valid (snp_req_valid),
      .snp_req_kind  (snp_req_kind),
      .snp_req_line  (snp_req_line),
      .snp_req_ready (snp_req_ready),
      .snp_rsp_valid (snp_rsp_valid),
      .snp_rsp_hit   (snp_rsp_hit),
      .snp_rsp_dirty (snp_rsp_dirty),
      .snp_rsp_data  (snp_rsp_data),
      .lock_req      (s_lreq),
      .lock_held     (s_held),
      .lock_rel      (s_rel),
      .cur_line      (s_line),
      .line_st       (mesi_t'(st_flat[s_line])),
      .line_data     (data_flat[s_line]),
      .we            (s_we),
      .wr_st         (s_wr_st)
   );
endmodule

// File: rtl/ccl_ctrl_chk.sv
module ccl_ctrl_chk
   import ccl_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [NUM_LINES-1:0][1:0]        st_flat,
   input logic [NUM_LINES-1:0][DATA_W-1:0] data_flat,
   input logic                             cpu_rsp_valid,
   input logic                             mem_req_valid,
   input logic                             mem_req_own,
   input logic [IDX_W-1:0]                 mem_req_line,
   input logic [IDX_W-1:0]                 m_line,
   input logic [IDX_W-1:0]                 s_line,
   input logic                             m_we,
   input logic                             s_we,
   input logic [NUM_LINES-1:0]             m_lreq_v,
   input logic [NUM_LINES-1:0]             s_lreq_v,
   input logic [NUM_LINES-1:0]             m_held_v,
   input logic [NUM_LINES-1:0]             s_held_v
);
   assert_rsp_not_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid |-> st_flat[m_line] != ST_I);

   assert_read_miss_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_own) |-> st_flat[mem_req_line] == ST_I);

   assert_own_req_not_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_own) |->
         (st_flat[mem_req_line] == ST_I || st_flat[mem_req_line] == ST_S));

   assert_no_same_line_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_we && s_we && m_line == s_line));

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line_chk
      assert_mod_by_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (st_flat[i] == ST_M && $past(st_flat[i]) != ST_M) |->
            $past(m_we && m_line == IDX_W'(i)));

      assert_data_by_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(data_flat[i]) |-> $past(m_we && m_line == IDX_W'(i)));

      assert_tie_to_snoop_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (m_lreq_v[i] && s_lreq_v[i] && !m_held_v[i] && !s_held_v[i]) |=> s_held_v[i]);

      assert_single_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({m_held_v[i], s_held_v[i]}));
   end
endmodule

bind coh_line_ctrl ccl_ctrl_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .st_flat       (st_flat),
   .data_flat     (data_flat),
   .cpu_rsp_valid (cpu_rsp_valid),
   .mem_req_valid (mem_req_valid),
   .mem_req_own   (mem_req_own),
   .mem_req_line  (mem_req_line),
   .m_line        (m_line),
   .s_line        (s_line),
   .m_we          (m_we),
   .s_we          (s_we),
   .m_lreq_v      (m_lreq_v),
   .s_lreq_v      (s_lreq_v),
   .m_held_v      (m_held_v),
   .s_held_v      (s_held_v)
);

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 4;
   localparam int DW = 8;
   localparam int IW = 2;

   localparam int I_ = 0, S_ = 1, E_ = 2, M_ = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req_valid = 0, cpu_req_write = 0;
   logic [IW-1:0] cpu_req_line = '0;
   logic [DW-1:0] cpu_req_wdata = '0;
   logic cpu_req_ready, cpu_rsp_valid;
   logic [DW-1:0] cpu_rsp_rdata;
   logic mem_req_valid, mem_req_own;
   logic [IW-1:0] mem_req_line;
   logic mem_rsp_valid = 0, mem_rsp_excl = 0;
   logic [DW-1:0] mem_rsp_data = '0;
   logic snp_req_valid = 0, snp_req_kind = 0;
   logic [IW-1:0] snp_req_line = '0;
   logic snp_req_ready, snp_rsp_valid, snp_rsp_hit, snp_rsp_dirty;
   logic [DW-1:0] snp_rsp_data;

   int checks = 0;
   int errors = 0;
   int mst [NL];
   logic [DW-1:0] mdat [NL];
   time t_cpu, t_snp;

   always #(CLK_PERIOD/2) clk = ~clk;

   coh_line_ctrl #(.NUM_LINES(NL), .DATA_W(DW)) uut (.*);

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cpu_op(input bit wr, input int ln, input logic [DW-1:0] wd,
                         input bit exp_req, input bit exp_own, input bit grant,
                         input bit deny_first, input logic [DW-1:0] fill,
                         input logic [DW-1:0] exp_rd, input int delay, input string req);
      int nreq = 0;
      int c = 0;
      @(negedge clk);
      chk(cpu_req_ready == 1'b1, "R11", "ready before request", cpu_req_ready, 1);
      cpu_req_valid = 1; cpu_req_write = wr; cpu_req_line = IW'(ln); cpu_req_wdata = wd;
      @(negedge clk);
      cpu_req_valid = 0;
      chk(cpu_req_ready == 1'b0, "R11", "ready after accept", cpu_req_ready, 0);
      while (!cpu_rsp_valid && c < 200) begin
         if (mem_req_valid) begin
            nreq++;
            chk(int'(mem_req_line) == ln, req, "request line", mem_req_line, ln);
            chk(mem_req_own == exp_own, req, "request own bit", mem_req_own, exp_own);
            repeat (delay) @(negedge clk);
            mem_rsp_valid = 1;
            mem_rsp_excl  = (deny_first && nreq == 1) ? 1'b0 : grant;
            mem_rsp_data  = fill;
            @(negedge clk);
            mem_rsp_valid = 0;
         end else begin
            @(negedge clk);
         end
         c++;
      end
      t_cpu = $time;
      chk(cpu_rsp_valid == 1'b1, req, "cpu response seen", cpu_rsp_valid, 1);
      chk(cpu_rsp_rdata == exp_rd, req, "cpu response data", cpu_rsp_rdata, exp_rd);
      chk(nreq == (exp_req ? (deny_first ? 2 : 1) : 0), req, "request count", nreq,
          exp_req ? (deny_first ? 2 : 1) : 0);
   endtask

   task automatic snoop_op(input bit kind, input int ln, input bit e_hit, input bit e_dirty,
                           input logic [DW-1:0] e_data, input string req);
      int c = 0;
      @(negedge clk);
      chk(snp_req_ready == 1'b1, req, "snoop ready", snp_req_ready, 1);
      snp_req_valid = 1; snp_req_kind = kind; snp_req_line = IW'(ln);
      @(negedge clk);
      snp_req_valid = 0;
      while (!snp_rsp_valid && c < 100) begin
         @(negedge clk);
         c++;
      end
      t_snp = $time;
      chk(snp_rsp_valid == 1'b1, req, "snoop response seen", snp_rsp_valid, 1);
      chk(snp_rsp_hit == e_hit, req, "snoop hit", snp_rsp_hit, e_hit);
      chk(snp_rsp_dirty == e_dirty, req, "snoop dirty", snp_rsp_dirty, e_dirty);
      chk(snp_rsp_data == e_data, req, "snoop data", snp_rsp_data, e_data);
   endtask

   // model-driven operations
   task automatic m_load(input int ln, input bit g, input logic [DW-1:0] fill, input string req);
      bit miss = (mst[ln] == I_);
      cpu_op(0, ln, '0, miss, 0, g, 0, fill, miss ? fill : mdat[ln], 0, req);
      if (miss) begin
         mst[ln] = g ? E_ : S_;
         mdat[ln] = fill;
      end
   endtask

   task automatic m_store(input int ln, input logic [DW-1:0] wd, input bit deny,
                          input logic [DW-1:0] fill, input string req);
      bit miss = (mst[ln] == I_ || mst[ln] == S_);
      cpu_op(1, ln, wd, miss, 1, 1, miss && deny, fill, wd, 0, req);
      mst[ln] = M_;
      mdat[ln] = wd;
   endtask

   task automatic m_snoop(input bit kind, input int ln, input string req);
      bit dirty = (mst[ln] == M_);
      snoop_op(kind, ln, mst[ln] != I_, dirty, dirty ? mdat[ln] : '0, req);
      if (kind) mst[ln] = I_;
      else if (mst[ln] == M_ || mst[ln] == E_) mst[ln] = S_;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      for (int i = 0; i < NL; i++) begin mst[i] = I_; mdat[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(cpu_req_ready == 1, "R1", "cpu ready", cpu_req_ready, 1);
      chk(snp_req_ready == 1, "R1", "snoop ready", snp_req_ready, 1);
      chk(cpu_rsp_valid == 0, "R1", "cpu rsp", cpu_rsp_valid, 0);
      chk(mem_req_valid == 0, "R1", "mem req", mem_req_valid, 0);
      chk(snp_rsp_valid == 0, "R1", "snoop rsp", snp_rsp_valid, 0);
      for (int i = 0; i < NL; i++) m_snoop(0, i, "R1");

      // R2/R5: load miss with exclusive grant, then hit
      m_load(0, 1, 8'hA5, "R2");
      m_load(0, 0, 8'h00, "R2");
      // R3/R5: store on Exclusive, no request
      m_store(0, 8'h3C, 0, 8'h00, "R3");
      // R6: share snoop on Modified
      m_snoop(0, 0, "R6");
      // R4: store on Shared needs ownership
      m_store(0, 8'h77, 0, 8'h11, "R4");
      // R7: invalidate on Modified
      m_snoop(1, 0, "R7");
      // R5: load with shared reply, store must request
      m_load(1, 0, 8'h5A, "R5");
      m_store(1, 8'h99, 0, 8'h5A, "R5");
      // R12: denied ownership then granted
      m_snoop(1, 2, "R7");
      m_store(2, 8'hE1, 1, 8'h42, "R12");
      m_snoop(0, 2, "R12");
      // R10: stray reply while idle is ignored
      m_snoop(1, 3, "R10");
      @(negedge clk);
      mem_rsp_valid = 1; mem_rsp_excl = 1; mem_rsp_data = 8'hEE;
      @(negedge clk);
      mem_rsp_valid = 0;
      m_load(3, 1, 8'h21, "R10");

      // R8: snoop served while main waits on controller
      m_snoop(1, 0, "R8");
      m_store(1, 8'h66, 0, 8'h00, "R8");
      fork
         cpu_op(0, 0, '0, 1, 0, 1, 0, 8'hC3, 8'hC3, 12, "R8");
         begin
            repeat (3) @(negedge clk);
            snoop_op(1, 1, 1, 1, 8'h66, "R8");
         end
      join
      chk(t_snp < t_cpu, "R8", "snoop answered before load done", int'(t_snp), int'(t_cpu));
      mst[0] = E_; mdat[0] = 8'hC3; mst[1] = I_;

      // R9: same-cycle store and invalidate on Exclusive line, snoop wins
      fork
         snoop_op(1, 0, 1, 0, '0, "R9");
         cpu_op(1, 0, 8'hB7, 1, 1, 1, 0, 8'h10, 8'hB7, 0, "R9");
      join
      mst[0] = M_; mdat[0] = 8'hB7;
      m_snoop(0, 0, "R9");

      // random mix
      for (int k = 0; k < 250; k++) begin
         int ln = int'($urandom % NL);
         int r  = int'($urandom % 10);
         if (r < 3)      m_load(ln, bit'($urandom % 2), DW'($urandom), "R2");
         else if (r < 6) m_store(ln, DW'($urandom), ($urandom % 4) == 0, DW'($urandom), "R4");
         else            m_snoop(bit'($urandom % 2), ln, "R6");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule